// File: doc/BRIEF.md
# Thermal Trip Throttle Controller

This block watches an asynchronous over-temperature flag from an on-die sensor. When the flag is raised and the controller is enabled, it records the operating point currently in use and asks a voltage-frequency sequencer to move to a low operating point that software has programmed. Once the sequencer reports that this downward move is finished, a wait timer starts. When the timer runs out and the die has cooled, the controller asks the sequencer to go back to the recorded point. If the die is still hot at that moment, the timer starts again and the controller stays at the low point.

The controller talks to the sequencer through three signals. It raises a one-cycle request with a target point, the sequencer holds a busy flag while it works, and it gives a one-cycle done pulse when it finishes. A request is never issued while busy is high, so it waits until the sequencer is free. Each finished automatic transition sets a sticky status bit, one for down and one for up. Software clears these bits by writing a one to them. The interrupt output is high when any status bit is set and the matching mask bit is also set. A small write-only register port holds the enable bit, the mask bits, the low point and the wait length.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: The over-temperature input passes through a two-flop synchroniser. A request caused by it cannot appear at the outputs until at least three rising edges after the input rises.
- R2: When idle, enabled and not busy, a synchronised over-temperature condition produces a request whose target equals the low-point register (address 1, bits OP_W-1:0).
- R3: The operating point on `cur_point` is recorded when the trip is detected. The up request targets that recorded value, even if `cur_point` changes while the block is throttled.
- R4: The controller must stay at the low point for a set wait after the down transition. The wait length is in the register at address 2. If the die is cool, the up request appears W+1 rising edges after the edge that samples the down `seq_done`, where W is that register value.
- R5: If the synchronised over-temperature signal is still high when the wait expires, no up request is made and the wait starts again from W.
- R6: `seq_req` is only asserted when `seq_busy` was low at the edge that issued it. A trip that happens while the sequencer is busy is held back until busy goes low.
- R7: Status bit 0 is set when the down transition completes and bit 1 is set when the up transition completes. Both bits stay set until software clears them.
- R8: Writing to address 3 clears each status bit whose data bit is 1 (bit 0 for down, bit 1 for up). Status bits written with 0 do not change.
- R9: `irq` is high exactly when (status bit 0 AND mask bit 1 of address 0) OR (status bit 1 AND mask bit 2 of address 0).
- R10: When the enable bit (address 0, bit 0) is clear, the over-temperature input is ignored and no request is issued.
- R11: `seq_req` is a single-cycle pulse.
- R12: After reset, `seq_req`, `irq` and the status bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ot_async | input | 1 | Over-temperature flag from the sensor, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 low point, 2 wait, 3 status clear |
| cfg_wdata | input | DW | Register write data |
| cur_point | input | OP_W | Operating point currently in use |
| seq_busy | input | 1 | Sequencer is busy with a transition |
| seq_done | input | 1 | Sequencer finished a transition (one-cycle pulse) |
| seq_req | output | 1 | Transition request (one-cycle pulse) |
| seq_target | output | OP_W | Target operating point for the request |
| irq | output | 1 | Masked interrupt |
| irq_status | output | 2 | Sticky status: bit 0 down done, bit 1 up done |

## Verification
The main function is tested with four patterns. A brief trip that cools quickly is used to measure the exact wait length to the up request. A trip that stays hot across one or more expiries shows that the timer re-arms and does not restore the point too early. During that long trip `cur_point` is changed, which separates the recorded pre-trip point from the live one. A trip that arrives while the sequencer is busy, and another while the block is disabled, show that a request is deferred in the first case and dropped in the second. Every request target is compared, in order, against a queue of expected targets.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_HOLD = 2'd2,
    ST_UP   = 2'd3
  } tt_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOW  = 2'd1;
  localparam logic [1:0] A_WAIT = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;

  // sticky bits: clear first, then set wins
  function automatic logic [1:0] sticky_next(input logic [1:0] cur,
                                             input logic [1:0] set,
                                             input logic [1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // irq from status and the mask pair {up,down}
  function automatic logic masked_irq(input logic [1:0] sts,
                                      input logic [1:0] msk);
    return |(sts & msk);
  endfunction

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
  import tt_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int CNT_W = 12,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             set_dn,
  input  logic             set_up,
  output logic             en,
  output logic [1:0]       mask,
  output logic [OP_W-1:0]  low_pt,
  output logic [CNT_W-1:0] wait_len,
  output logic [1:0]       status,
  output logic [1:0]       clr_vec
);
  assign clr_vec = (we && addr == A_CLR) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      mask     <= 2'b00;
      low_pt   <= '0;
      wait_len <= '0;
      status   <= 2'b00;
    end else begin
      if (we) begin
        case (addr)
          A_CTRL: begin
            en   <= wdata[0];
            mask <= wdata[2:1];
          end
          A_LOW:  low_pt   <= wdata[OP_W-1:0];
          A_WAIT: wait_len <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      status <= sticky_next(status, {set_up, set_dn}, clr_vec);
    end
  end
endmodule

// File: rtl/tt_wait_timer.sv
module tt_wait_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import tt_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int CNT_W = 12,
  parameter int DW    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ot_async,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [OP_W-1:0] cur_point,
  input  logic            seq_busy,
  input  logic            seq_done,
  output logic            seq_req,
  output logic [OP_W-1:0] seq_target,
  output logic            irq,
  output logic [1:0]      irq_status
);
  tt_state_e        st;
  logic             hot_s;
  logic             ctl_en;
  logic [1:0]       ctl_mask;
  logic [OP_W-1:0]  low_pt;
  logic [CNT_W-1:0] wait_len;
  logic [1:0]       w1c_vec;
  logic [OP_W-1:0]  saved_pt;
  logic             expired;

  // named events for the checker
  logic trip_evt, up_evt, rehot_evt, dn_done, up_done, in_throttle;

  tt_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ot_async), .q_sync(hot_s)
  );

  tt_cfg_regs #(.OP_W(OP_W), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .set_dn(dn_done), .set_up(up_done),
    .en(ctl_en), .mask(ctl_mask), .low_pt(low_pt), .wait_len(wait_len),
    .status(irq_status), .clr_vec(w1c_vec)
  );

  tt_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(dn_done | rehot_evt), .load_val(wait_len),
    .run(st == ST_HOLD), .expired(expired)
  );

  always_comb begin
    trip_evt    = (st == ST_IDLE) && ctl_en && hot_s && !seq_busy;
    rehot_evt   = (st == ST_HOLD) && expired && hot_s;
    up_evt      = (st == ST_HOLD) && expired && !hot_s && ctl_en && !seq_busy;
    dn_done     = (st == ST_DOWN) && seq_done;
    up_done     = (st == ST_UP) && seq_done;
    in_throttle = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      seq_req    <= 1'b0;
      seq_target <= '0;
      saved_pt   <= '0;
    end else begin
      seq_req <= trip_evt | up_evt;
      if (trip_evt) begin
        saved_pt   <= cur_point;
        seq_target <= low_pt;
      end else if (up_evt) begin
        seq_target <= saved_pt;
      end
      case (st)
        ST_IDLE: if (trip_evt) st <= ST_DOWN;
        ST_DOWN: if (seq_done) st <= ST_HOLD;
        ST_HOLD: if (up_evt)   st <= ST_UP;
        ST_UP:   if (seq_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign irq = masked_irq(irq_status, ctl_mask);
endmodule

module tt_checker #(
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            seq_req,
  input logic            seq_busy,
  input logic [OP_W-1:0] seq_target,
  input logic            irq,
  input logic [1:0]      irq_status,
  input logic            ctl_en,
  input logic [OP_W-1:0] low_pt,
  input logic [OP_W-1:0] saved_pt,
  input logic            in_throttle,
  input logic [1:0]      w1c_vec
);
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |=> !seq_req);

  p_req_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> $past(!seq_busy));

  p_req_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> $past(ctl_en));

  p_down_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_throttle) |-> (seq_req && seq_target == $past(low_pt)));

  p_saved_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_throttle && $past(in_throttle)) |-> $stable(saved_pt));

  p_dn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_status[0]) && !$past(w1c_vec[0])) |-> irq_status[0]);

  p_up_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_status[1]) && !$past(w1c_vec[1])) |-> irq_status[1]);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_status != 2'b00));
endmodule

bind thermal_throttle_ctrl tt_checker #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_busy(seq_busy),
  .seq_target(seq_target), .irq(irq), .irq_status(irq_status),
  .ctl_en(ctl_en), .low_pt(low_pt), .saved_pt(saved_pt),
  .in_throttle(in_throttle), .w1c_vec(w1c_vec)
);

// File: tb/test_thermal_throttle_ctrl.sv
`timescale 1ns/1ps
module test_thermal_throttle_ctrl;
  localparam int OP_W = 4, CNT_W = 12, DW = 16;
  localparam int W = 5;

  logic clk = 1'b0, rst_n = 1'b0, ot = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [OP_W-1:0] cur_op = 4'hA;
  logic ext_busy = 1'b0;
  logic m_busy = 1'b0, m_done = 1'b0;
  logic seq_req, irq;
  logic [OP_W-1:0] seq_target;
  logic [1:0] irq_status;

  int total = 0, bad = 0, cyc = 0, req_cnt = 0, req_cyc = 0, done_cyc = 0;
  int m_cnt = 0;
  logic [OP_W-1:0] m_tgt = '0;
  logic prev_req = 1'b0;
  logic finished = 1'b0;
  logic [OP_W-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  thermal_throttle_ctrl #(.OP_W(OP_W), .CNT_W(CNT_W), .DW(DW)) i_thermal_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .ot_async(ot), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cur_point(cur_op), .seq_busy(m_busy | ext_busy),
    .seq_done(m_done), .seq_req(seq_req), .seq_target(seq_target),
    .irq(irq), .irq_status(irq_status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(input logic [OP_W-1:0] t, input string tag);
    exp_q.push_back(t);
    tag_q.push_back(tag);
  endtask

  // sequencer model
  always @(negedge clk) begin
    if (m_done) begin
      m_done = 1'b0; m_busy = 1'b0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        m_done = 1'b1; done_cyc = cyc; cur_op = m_tgt;
      end else m_cnt--;
    end else if (rst_n && seq_req) begin
      m_busy = 1'b1; m_cnt = 3; m_tgt = seq_target;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (seq_req) begin
        req_cnt++; req_cyc = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected request", seq_target, -1);
        else begin
          automatic logic [OP_W-1:0] e = exp_q.pop_front();
          automatic string tg = tag_q.pop_front();
          chk(seq_target == e, tg, seq_target, e);
        end
        chk(!prev_req, "R11 pulse width", 2, 1);
      end
      prev_req = seq_req;
    end
  end

  task automatic cfg(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_reqs(input int n);
    for (int i = 0; i < 300 && req_cnt < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300 && (m_busy || m_done); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R12
    chk(seq_req == 1'b0, "R12 req reset", seq_req, 0);
    chk(irq == 1'b0, "R12 irq reset", irq, 0);
    chk(irq_status == 2'b00, "R12 status reset", irq_status, 0);
    rst_n = 1'b1;
    cfg(2'd0, 32'h7);    // enable, both masks
    cfg(2'd1, 32'h3);    // low point
    cfg(2'd2, W);

    // long trip: stays hot across expiries, cur_point moves
    expect_req(4'h3, "R2 down target");
    n = req_cnt;
    @(negedge clk); ot = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req_cnt == n, "R1 sync delay", req_cnt, n);
    wait_reqs(n + 1);
    wait_idle();
    chk(irq_status[0] == 1'b1, "R7 down status", irq_status[0], 1);
    chk(irq == 1'b1, "R9 irq down", irq, 1);
    cur_op = 4'h7;
    repeat (3 * W + 6) @(negedge clk);
    chk(req_cnt == n + 1, "R5 no restore while hot", req_cnt, n + 1);
    expect_req(4'hA, "R3 restore saved point");
    ot = 1'b0;
    wait_reqs(n + 2);
    wait_idle();
    chk(irq_status == 2'b11, "R7 both status sticky", irq_status, 3);

    // R8 partial clear
    cfg(2'd3, 32'h1);
    chk(irq_status == 2'b10, "R8 clear down only", irq_status, 2);
    chk(irq == 1'b1, "R9 irq up masked on", irq, 1);
    cfg(2'd0, 32'h3);    // mask up off
    chk(irq == 1'b0, "R9 irq up masked off", irq, 0);
    cfg(2'd3, 32'h0);
    chk(irq_status == 2'b10, "R8 zero write no effect", irq_status, 2);
    cfg(2'd3, 32'h2);
    chk(irq_status == 2'b00, "R8 clear up", irq_status, 0);
    cfg(2'd0, 32'h7);

    // short trip: exact wait length
    cfg(2'd1, 32'h5);
    expect_req(4'h5, "R2 second down target");
    n = req_cnt;
    @(negedge clk); ot = 1'b1;
    wait_reqs(n + 1);
    ot = 1'b0;
    expect_req(4'hA, "R4 restore after wait");
    for (int i = 0; i < 300 && !irq_status[0]; i++) @(negedge clk);
    wait_reqs(n + 2);
    chk(req_cyc - done_cyc == W + 2, "R4 wait length", req_cyc - done_cyc, W + 2);
    wait_idle();
    cfg(2'd3, 32'h3);

    // disabled: hot ignored
    cfg(2'd0, 32'h6);
    n = req_cnt;
    ot = 1'b1;
    repeat (20) @(negedge clk);
    chk(req_cnt == n, "R10 disabled no request", req_cnt, n);
    chk(irq_status == 2'b00, "R10 disabled no status", irq_status, 0);
    ot = 1'b0;
    repeat (4) @(negedge clk);

    // busy deferral
    ext_busy = 1'b1;
    cfg(2'd0, 32'h7);
    ot = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_cnt == n, "R6 deferred while busy", req_cnt, n);
    expect_req(4'h5, "R6 request after busy");
    ext_busy = 1'b0;
    wait_reqs(n + 1);
    chk(req_cnt == n + 1, "R6 issued after busy", req_cnt, n + 1);
    ot = 1'b0;
    expect_req(4'hA, "R3 restore after deferred trip");
    wait_reqs(n + 2);
    wait_idle();
    chk(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 0);
    summary();
  end
endmodule